// File: doc/BRIEF.md
# Write Cycle Qualifier

This block sits in front of a flash command decoder and turns three raw, active-low bus controls (chip select, write strobe, read enable) into clean, single-cycle write events. Each control line is brought into the fast clock domain through a two-flop synchronizer. It then goes through a run-length filter, so that a level change is believed only after it has been seen for a set number of consecutive samples. Short noise pulses on the control lines therefore never open or close a write cycle.

A write cycle is open while chip select and write strobe are both low and read enable is high. The address is taken when the cycle opens, which is the later of the two falling edges. The data is taken when the first of chip select or write strobe returns high. One clock later a single-cycle pulse presents both values. Read enable going low inside a cycle cancels it.

A lockout guards the command logic. Lockout is active out of reset, while a power-on indicator is high, and while a supply-low flag is high. It is released only once both flags are clear and the filtered write strobe has been seen high. A write strobe that was already low at power-up therefore cannot deliver a command on its first rising edge. While the supply-low flag is set, the block also asks for a reset of the command logic.

Top module: `wrq_top`

## Requirements
- R1: After reset `wr_valid` and `cmd_rst_req` are 0.
- R2: With read enable high, a cycle in which chip select and write strobe are both low and then released gives exactly one `wr_valid` pulse, carrying the captured address and data.
- R3: No pulse is produced if read enable is low for the whole cycle, or if read enable goes low while the cycle is open.
- R4: Toggling the write strobe while chip select is high produces no pulse.
- R5: `wr_addr` equals the address bus value at the later of the two falling edges, for either order of falling edges.
- R6: `wr_data` equals the data bus value at the earlier of the two rising edges, for either order of rising edges.
- R7: A control level held for fewer than `FILT` consecutive clock samples is ignored; a level held for `FILT` samples is accepted.
- R8: If chip select and write strobe are low with read enable high while the power-on indicator is set, the next rising edge of the write strobe gives no pulse.
- R9: While `supply_low` is 1, no pulse is produced, any open cycle is dropped, and `cmd_rst_req` is 1 one clock after `supply_low` rises.
- R10: After `supply_low` clears, writes stay blocked until the write strobe has been seen high; the next complete cycle after that is accepted.
- R11: `wr_valid` is never high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n_raw | input | 1 | Raw chip select, active low |
| we_n_raw | input | 1 | Raw write strobe, active low |
| oe_n_raw | input | 1 | Raw read enable, active low |
| addr_in | input | AW | Address bus |
| data_in | input | DW | Data bus |
| supply_low | input | 1 | Low supply flag |
| por_active | input | 1 | High while power-on is in progress |
| wr_valid | output | 1 | One-clock qualified write pulse |
| wr_addr | output | AW | Captured write address |
| wr_data | output | DW | Captured write data |
| cmd_rst_req | output | 1 | Reset request to the command logic |

## Verification
The bench builds the block with `FILT` = 3, an 18-bit address and a 16-bit data bus. With this short filter, a two-sample glitch and a three-sample pulse sit on either side of the acceptance threshold, so both outcomes can be checked directly. The small value also keeps each bus phase to about ten clocks. That leaves room to swap the address and data buses to decoy values between the falling and rising edges, which shows which edge each capture used.

// File: rtl/wrq_pkg.sv
// Shared types for the write cycle qualifier.
package wrq_pkg;
    // Write-cycle tracker state.
    typedef enum logic {
        CYC_IDLE   = 1'b0,
        CYC_ACTIVE = 1'b1
    } cyc_state_t;
endpackage

// File: rtl/wrq_deglitch.sv
// Run-length deglitcher for one control line.
// Assumes din is asynchronous. A two-flop synchronizer feeds a counter, and
// dout only takes a new level once it has been sampled FILT times in a row.
module wrq_deglitch #(
    parameter int   FILT    = 4,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT - 1);

    logic         s1, s2;
    logic [CW-1:0] run;

    // Bring the raw line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= RST_VAL;
            s2 <= RST_VAL;
        end else begin
            s1 <= din;
            s2 <= s1;
        end
    end

    // Count consecutive differing samples and switch at FILT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= RST_VAL;
            run  <= '0;
        end else if (s2 == dout) begin
            run <= '0;
        end else if (run == LAST) begin
            dout <= s2;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    // R7: a level only moves after FILT agreeing samples.
    p_min_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(run) == LAST));
endmodule

// File: rtl/wrq_lockout.sv
// Write lockout and command-logic reset request.
// Assumes we_idle is the filtered write strobe (1 = high, idle). Lockout is
// set by reset, power-on or low supply. It clears only when both flags are
// low and the strobe is idle.
module wrq_lockout (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic por_active,
    input  logic we_idle,
    output logic lock,
    output logic rst_req
);
    // Hold lockout until the supply is good and the write strobe is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock <= 1'b1;
        else if (supply_low || por_active)
            lock <= 1'b1;
        else if (we_idle)
            lock <= 1'b0;
    end

    // Request a command-logic reset while the supply is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req <= 1'b0;
        else
            rst_req <= supply_low;
    end

    // R9: a reset request is always accompanied by lockout.
    p_req_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> lock);

    // R10: lockout releases only after an idle write strobe.
    p_release_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> $past(we_idle));
endmodule

// File: rtl/wrq_cycle.sv
// Write-cycle tracker on filtered active-low controls.
// Takes the address when chip select and write strobe are both low with read
// enable high (the later fall). Takes the data when either returns high (the
// earlier rise) and emits a one-clock pulse. Read enable low or lockout
// cancels an open cycle.
module wrq_cycle
    import wrq_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          lock,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    cyc_state_t    state;
    logic [AW-1:0] addr_hold;
    logic          open_cond;

    // Write-cycle condition on the filtered lines.
    always_comb open_cond = !ce_n && !we_n && oe_n;

    // Track the cycle, capture the bus and emit the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= CYC_IDLE;
            addr_hold <= '0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_valid  <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            case (state)
                CYC_IDLE: begin
                    if (open_cond && !lock) begin
                        addr_hold <= addr_in;
                        state     <= CYC_ACTIVE;
                    end
                end
                CYC_ACTIVE: begin
                    if (lock || !oe_n) begin
                        state <= CYC_IDLE;
                    end else if (ce_n || we_n) begin
                        wr_data  <= data_in;
                        wr_addr  <= addr_hold;
                        wr_valid <= 1'b1;
                        state    <= CYC_IDLE;
                    end
                end
                default: state <= CYC_IDLE;
            endcase
        end
    end

    // R11: the pulse lasts one clock.
    p_pulse_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R3: a pulse needs read enable high at the closing edge.
    p_oe_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(oe_n));

    // R9: lockout suppresses the pulse.
    p_no_write_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> !wr_valid);

    // R2: a pulse follows an open cycle.
    p_pulse_from_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(state == CYC_ACTIVE));
endmodule

// File: rtl/wrq_top.sv
// Write cycle qualifier top level.
// Deglitches the three raw active-low controls, applies power-up and
// low-supply lockout, and passes qualified writes to the command decoder.
// Assumes the address and data buses are stable while the filtered edges land.
module wrq_top #(
    parameter int AW   = 18,
    parameter int DW   = 16,
    parameter int FILT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n_raw,
    input  logic          we_n_raw,
    input  logic          oe_n_raw,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic          supply_low,
    input  logic          por_active,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          cmd_rst_req
);
    localparam int NCTL = 3;

    logic [NCTL-1:0] ctl_raw;
    logic [NCTL-1:0] ctl_flt;
    logic            lock;

    // Gather the control lines: bit 0 chip select, 1 write strobe, 2 read enable.
    always_comb ctl_raw = {oe_n_raw, we_n_raw, ce_n_raw};

    for (genvar g = 0; g < NCTL; g++) begin : g_flt
        wrq_deglitch #(.FILT(FILT), .RST_VAL(1'b1)) i_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (ctl_raw[g]),
            .dout (ctl_flt[g])
        );
    end

    wrq_lockout i_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_low(supply_low),
        .por_active(por_active),
        .we_idle   (ctl_flt[1]),
        .lock      (lock),
        .rst_req   (cmd_rst_req)
    );

    wrq_cycle #(.AW(AW), .DW(DW)) i_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ctl_flt[0]),
        .we_n    (ctl_flt[1]),
        .oe_n    (ctl_flt[2]),
        .lock    (lock),
        .addr_in (addr_in),
        .data_in (data_in),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );
endmodule

// File: tb/test_wrq_top.sv
// Self-checking bench for wrq_top.
module test_wrq_top;
    localparam int AW   = 18;
    localparam int DW   = 16;
    localparam int FILT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          supply_low = 1'b0;
    logic          por_active = 1'b1;
    logic          wr_valid, cmd_rst_req;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int n_chk = 0, n_fail = 0, pulses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wrq_top #(.AW(AW), .DW(DW), .FILT(FILT)) i_wrq_top (
        .clk(clk), .rst_n(rst_n), .ce_n_raw(ce_n), .we_n_raw(we_n),
        .oe_n_raw(oe_n), .addr_in(addr), .data_in(data),
        .supply_low(supply_low), .por_active(por_active),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_rst_req(cmd_rst_req)
    );

    // Count write pulses away from the active edge.
    always @(negedge clk) if (rst_n && wr_valid) pulses++;

    // Vectors: {ce falls first, we rises first, address, data}.
    localparam logic [35:0] VEC [4] = '{
        {1'b1, 1'b1, 18'h15555, 16'h00A5},
        {1'b0, 1'b1, 18'h2AAAA, 16'h5A5A},
        {1'b1, 1'b0, 18'h00F0F, 16'hFFFF},
        {1'b0, 1'b0, 18'h3C003, 16'h1234}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One write cycle with the given edge orders. The buses carry decoys
    // outside their capture windows.
    task automatic do_write(input bit ce_first, input bit we_rise_first,
                            input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = ~a; data = ~d;
        if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
        step(8);
        addr = a;
        step(1);
        if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
        step(8);
        addr = ~a; data = d;
        step(2);
        if (we_rise_first) we_n = 1'b1; else ce_n = 1'b1;
        step(8);
        data = ~d;
        ce_n = 1'b1; we_n = 1'b1;
        step(10);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int p0;
        // R8: controls already in a write state at power-up.
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        step(4);
        rst_n = 1'b1;
        step(1);
        chk(wr_valid == 1'b0, "R1 wr_valid after reset", 32'(wr_valid), 0);
        chk(cmd_rst_req == 1'b0, "R1 cmd_rst_req after reset", 32'(cmd_rst_req), 0);
        step(10);
        por_active = 1'b0;
        step(10);
        p0 = pulses;
        we_n = 1'b1;
        step(12);
        ce_n = 1'b1;
        step(10);
        chk(pulses == p0, "R8 first strobe rise after power-up", 32'(pulses - p0), 0);

        // R2 R5 R6: table of edge orderings.
        for (int i = 0; i < 4; i++) begin
            p0 = pulses;
            do_write(VEC[i][35], VEC[i][34], VEC[i][33:16], VEC[i][15:0]);
            chk(pulses == p0 + 1, "R2 one pulse per cycle", 32'(pulses - p0), 1);
            chk(wr_addr == VEC[i][33:16], "R5 address at later fall", 32'(wr_addr), 32'(VEC[i][33:16]));
            chk(wr_data == VEC[i][15:0], "R6 data at earlier rise", 32'(wr_data), 32'(VEC[i][15:0]));
        end

        // R3: read enable low for the whole cycle.
        oe_n = 1'b0; p0 = pulses;
        do_write(1'b1, 1'b1, 18'h00011, 16'h0011);
        oe_n = 1'b1; step(6);
        chk(pulses == p0, "R3 read enable low throughout", 32'(pulses - p0), 0);

        // R3: read enable falls inside an open cycle.
        p0 = pulses;
        ce_n = 1'b0; we_n = 1'b0; step(10);
        oe_n = 1'b0; step(10);
        we_n = 1'b1; ce_n = 1'b1; step(10);
        oe_n = 1'b1; step(10);
        chk(pulses == p0, "R3 read enable falls mid-cycle", 32'(pulses - p0), 0);

        // R4: write strobe toggled with chip select high.
        p0 = pulses;
        for (int k = 0; k < 3; k++) begin
            we_n = 1'b0; step(8); we_n = 1'b1; step(8);
        end
        chk(pulses == p0, "R4 chip select high", 32'(pulses - p0), 0);

        // R7: strobe glitch shorter than FILT samples.
        p0 = pulses;
        ce_n = 1'b0; step(8);
        we_n = 1'b0; step(FILT - 1); we_n = 1'b1;
        step(10); ce_n = 1'b1; step(10);
        chk(pulses == p0, "R7 short strobe rejected", 32'(pulses - p0), 0);

        // R7: strobe held exactly FILT samples is accepted.
        p0 = pulses; addr = 18'h00123; data = 16'h0456;
        ce_n = 1'b0; step(8);
        we_n = 1'b0; step(FILT); we_n = 1'b1;
        step(10); ce_n = 1'b1; step(10);
        chk(pulses == p0 + 1, "R7 strobe of FILT samples accepted", 32'(pulses - p0), 1);

        // R7: short high glitch inside a cycle does not close it.
        p0 = pulses;
        addr = 18'h00777; ce_n = 1'b0; we_n = 1'b0; step(10);
        we_n = 1'b1; step(FILT - 1); we_n = 1'b0; step(10);
        data = 16'hBEEF; step(2);
        we_n = 1'b1; step(10); ce_n = 1'b1; step(10);
        chk(pulses == p0 + 1, "R7 mid-cycle glitch ignored", 32'(pulses - p0), 1);
        chk(wr_data == 16'hBEEF, "R7 data after glitch", 32'(wr_data), 32'hBEEF);

        // R9: low supply drops an open cycle and requests reset.
        p0 = pulses;
        ce_n = 1'b0; we_n = 1'b0; step(10);
        supply_low = 1'b1; step(2);
        chk(cmd_rst_req == 1'b1, "R9 reset request while supply low", 32'(cmd_rst_req), 1);
        step(5);
        supply_low = 1'b0; step(3);
        chk(cmd_rst_req == 1'b0, "R9 reset request clears", 32'(cmd_rst_req), 0);
        // R10: strobe still low, so its rise must not count.
        we_n = 1'b1; step(10); ce_n = 1'b1; step(10);
        chk(pulses == p0, "R10 no write until strobe idle", 32'(pulses - p0), 0);

        // R9: complete cycle while supply low.
        supply_low = 1'b1; p0 = pulses;
        do_write(1'b0, 1'b1, 18'h0AAAA, 16'h0F0F);
        chk(pulses == p0, "R9 write ignored under low supply", 32'(pulses - p0), 0);
        supply_low = 1'b0; step(6);

        // R10: writes resume after the idle strobe.
        p0 = pulses;
        do_write(1'b1, 1'b0, 18'h01357, 16'h2468);
        chk(pulses == p0 + 1, "R10 write accepted after recovery", 32'(pulses - p0), 1);
        chk(wr_addr == 18'h01357, "R10 address after recovery", 32'(wr_addr), 32'h01357);

        // R11: back-to-back cycles yield one pulse each.
        p0 = pulses;
        do_write(1'b0, 1'b0, 18'h00001, 16'h0001);
        do_write(1'b1, 1'b1, 18'h00002, 16'h0002);
        chk(pulses == p0 + 2, "R11 one-clock pulse per cycle", 32'(pulses - p0), 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule